// File: doc/BRIEF.md
# Linear Additive Delay Response Predictor

This block predicts the response of a two-chain delay-race circuit with a configurable number of stages by treating the circuit as purely linear and additive. It keeps one signed table entry per stage. An entry is the chain-to-chain delay difference observed when only that stage's challenge bit is 1 and every other bit is 0. The all-zero challenge is the reference, and its own difference is taken as zero.

To get a prediction, the caller loads the table through a write port, presents a challenge and pulses a start strobe. The block then adds the entries of all set challenge bits, one stage per clock cycle. It reports the signed total, the response bit taken from the sign of that total, and a flag that marks a total of exactly zero as undefined. A one-cycle valid pulse marks each new result. The table is a plain single-write, registered-read memory, so block RAM can be inferred for it.

Top module: `delay_resp_predictor`

## Requirements
- R1: While reset is high and after it is released, pred_diff, pred_bit, pred_tie and pred_vld are all 0.
- R2: A cycle with tbl_we high stores tbl_val, a signed 16-bit difference in picoseconds, at entry tbl_idx. Challenge bit i (bit 0 is the least significant) selects entry i, and a rewritten entry is used by every later prediction.
- R3: pred_diff is the exact sum of the entries whose challenge bit is 1. For example, challenge 8'b0000_0111 adds entries 0, 1 and 2.
- R4: When the sum is greater than zero, pred_bit is 1 and pred_tie is 0.
- R5: When the sum is less than zero, pred_bit is 0 and pred_tie is 0.
- R6: When the sum is exactly zero, pred_tie is 1 and pred_bit is 0, including when the set entries cancel each other.
- R7: The all-zero reference challenge gives pred_diff 0 with pred_tie 1.
- R8: The challenge is captured at the clock edge where pred_go is high and the block is idle. pred_vld is high for exactly one cycle, N_STAGES cycles after that edge. The result outputs hold their values until the next result.
- R9: A pred_go that arrives while a sum is still being accumulated has no effect. The running result and its timing are unchanged, and no extra valid pulse follows.
- R10: The sum never overflows. With all eight entries at -32768 the result is -262144, and with all eight at 32767 it is 262136.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 3 | Stage index to write |
| tbl_val | input | 16 | Signed per-stage delay difference, ps |
| chal | input | 8 | Challenge vector, captured on an accepted strobe |
| pred_go | input | 1 | Start a prediction |
| pred_diff | output | 19 | Signed predicted chain difference, ps |
| pred_bit | output | 1 | Predicted response bit |
| pred_tie | output | 1 | Prediction undefined (difference exactly zero) |
| pred_vld | output | 1 | One-cycle pulse marking a new result |

## Verification
The strobe is applied half a cycle before a rising edge. The bench samples every output on falling edges, so it sees pred_vld still low one falling edge before the result is due. On the N_STAGES-th falling edge after the accepting edge, it compares the difference, bit and flag against a sum computed from its own copy of the table. For the ignored-strobe case, a second strobe with a different challenge is pulsed in the third cycle of an accumulation. The bench then checks that the result still arrives on the original cycle with the original value and that pred_vld stays low for a full further N_STAGES cycles. A counter in the checker module independently tracks when each accepted strobe is due and requires pred_vld to match it on every cycle.

// File: rtl/dlp_pkg.sv
`timescale 1ns/1ps
package dlp_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  function automatic int sum_width(input int entry_w, input int stages);
    return entry_w + $clog2(stages);
  endfunction
endpackage

// File: rtl/dlp_table.sv
`timescale 1ns/1ps
module dlp_table #(
  parameter int N_STAGES = 8,
  parameter int DW       = 16,
  localparam int IW      = $clog2(N_STAGES)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [IW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);
  logic signed [DW-1:0] mem [N_STAGES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dlp_seq.sv
`timescale 1ns/1ps
module dlp_seq
  import dlp_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int DW       = 16,
  localparam int IW      = $clog2(N_STAGES),
  localparam int AW      = sum_width(DW, N_STAGES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [N_STAGES-1:0]  chal,
  input  logic signed [DW-1:0] rdata,
  output logic [IW-1:0]        raddr,
  output logic                 fin,
  output logic signed [AW-1:0] total
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_STAGES - 1);
  localparam logic [IW:0]   DEPTH    = (IW+1)'(N_STAGES);

  seq_state_t            state;
  logic [IW-1:0]         step;
  logic [N_STAGES-1:0]   chal_q;
  logic signed [AW-1:0]  acc;
  logic signed [AW-1:0]  term;
  logic [IW:0]           step_nxt;

  assign step_nxt = {1'b0, step} + 1'b1;
  assign raddr    = (state == ST_RUN && step_nxt < DEPTH) ? step_nxt[IW-1:0] : '0;
  assign term     = chal_q[step] ? AW'(rdata) : '0;
  assign total    = acc + term;
  assign fin      = (state == ST_RUN) && (step == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      step   <= '0;
      chal_q <= '0;
      acc    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            chal_q <= chal;
            acc    <= '0;
            step   <= '0;
            state  <= ST_RUN;
          end
        end
        default: begin
          acc <= total;
          if (step == LAST_IDX) begin
            state <= ST_IDLE;
            step  <= '0;
          end else begin
            step <= step_nxt[IW-1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dlp_decide.sv
`timescale 1ns/1ps
module dlp_decide #(
  parameter int AW = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fin,
  input  logic signed [AW-1:0] total,
  output logic signed [AW-1:0] diff,
  output logic                 resp,
  output logic                 tie,
  output logic                 vld
);
  logic is_zero;
  logic is_pos;

  assign is_zero = (total == '0);
  assign is_pos  = !total[AW-1] && !is_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      diff <= '0;
      resp <= 1'b0;
      tie  <= 1'b0;
      vld  <= 1'b0;
    end else begin
      vld <= fin;
      if (fin) begin
        diff <= total;
        resp <= is_pos;
        tie  <= is_zero;
      end
    end
  end
endmodule

// File: rtl/delay_resp_predictor.sv
`timescale 1ns/1ps
module delay_resp_predictor
  import dlp_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int DW       = 16,
  localparam int IW      = $clog2(N_STAGES),
  localparam int AW      = sum_width(DW, N_STAGES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tbl_we,
  input  logic [IW-1:0]        tbl_idx,
  input  logic signed [DW-1:0] tbl_val,
  input  logic [N_STAGES-1:0]  chal,
  input  logic                 pred_go,
  output logic signed [AW-1:0] pred_diff,
  output logic                 pred_bit,
  output logic                 pred_tie,
  output logic                 pred_vld
);
  localparam logic [IW:0] DEPTH = (IW+1)'(N_STAGES);

  logic                 we_ok;
  logic [IW-1:0]        rd_addr;
  logic signed [DW-1:0] rd_data;
  logic                 fin;
  logic signed [AW-1:0] total;

  assign we_ok = tbl_we && ({1'b0, tbl_idx} < DEPTH);

  dlp_table #(.N_STAGES(N_STAGES), .DW(DW)) u_table (
    .clk   (clk),
    .we    (we_ok),
    .waddr (tbl_idx),
    .wdata (tbl_val),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  dlp_seq #(.N_STAGES(N_STAGES), .DW(DW)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .go    (pred_go),
    .chal  (chal),
    .rdata (rd_data),
    .raddr (rd_addr),
    .fin   (fin),
    .total (total)
  );

  dlp_decide #(.AW(AW)) u_decide (
    .clk   (clk),
    .rst   (rst),
    .fin   (fin),
    .total (total),
    .diff  (pred_diff),
    .resp  (pred_bit),
    .tie   (pred_tie),
    .vld   (pred_vld)
  );
endmodule

// File: rtl/dlp_chk.sv
`timescale 1ns/1ps
module dlp_chk #(
  parameter int N_STAGES = 8,
  parameter int AW       = 19
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pred_go,
  input logic signed [AW-1:0] pred_diff,
  input logic                 pred_bit,
  input logic                 pred_tie,
  input logic                 pred_vld
);
  localparam int CW = $clog2(N_STAGES + 1);
  localparam logic [CW-1:0] LAST = CW'(N_STAGES);

  logic          ck_busy;
  logic [CW-1:0] ck_cnt;
  logic          due_q;

  // Independent latency model: counts cycles since an accepted strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_busy <= 1'b0;
      ck_cnt  <= '0;
      due_q   <= 1'b0;
    end else begin
      due_q <= ck_busy && (ck_cnt == LAST);
      if (!ck_busy) begin
        if (pred_go) begin
          ck_busy <= 1'b1;
          ck_cnt  <= CW'(1);
        end
      end else if (ck_cnt == LAST) begin
        ck_busy <= 1'b0;
      end else begin
        ck_cnt <= ck_cnt + 1'b1;
      end
    end
  end

  assert_vld_latency_R8: assert property (@(posedge clk) disable iff (rst)
    pred_vld == due_q);

  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    pred_vld |=> !pred_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !pred_vld |-> ($stable(pred_diff) && $stable(pred_tie) && $stable(pred_bit)));

  assert_tie_zero_R6: assert property (@(posedge clk) disable iff (rst)
    pred_vld |-> (pred_tie == (pred_diff == '0)));

  assert_tie_bit_R6: assert property (@(posedge clk) disable iff (rst)
    pred_tie |-> !pred_bit);

  assert_bit_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (pred_vld && !pred_tie) |-> (pred_bit == !pred_diff[AW-1]));

  assert_no_extra_R9: assert property (@(posedge clk) disable iff (rst)
    (pred_vld && !$past(ck_busy)) |-> 1'b0);
endmodule

bind delay_resp_predictor dlp_chk #(.N_STAGES(N_STAGES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pred_go   (pred_go),
  .pred_diff (pred_diff),
  .pred_bit  (pred_bit),
  .pred_tie  (pred_tie),
  .pred_vld  (pred_vld)
);

// File: tb/test_delay_resp_predictor.sv
`timescale 1ns/1ps
module test_delay_resp_predictor;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = DW + $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 tbl_we = 1'b0;
  logic [2:0]           tbl_idx = '0;
  logic signed [DW-1:0] tbl_val = '0;
  logic [N-1:0]         chal = '0;
  logic                 pred_go = 1'b0;
  logic signed [AW-1:0] pred_diff;
  logic                 pred_bit;
  logic                 pred_tie;
  logic                 pred_vld;

  int tests = 0;
  int fails = 0;
  int tbl [N];

  always #4 clk = ~clk;

  delay_resp_predictor #(.N_STAGES(N), .DW(DW)) i_delay_resp_predictor (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
    .chal(chal), .pred_go(pred_go), .pred_diff(pred_diff), .pred_bit(pred_bit),
    .pred_tie(pred_tie), .pred_vld(pred_vld)
  );

  function automatic int exp_sum(input logic [N-1:0] c);
    int s = 0;
    for (int i = 0; i < N; i++) if (c[i]) s += tbl[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_val = DW'(val);
    @(negedge clk);
    tbl_we = 1'b0;
    tbl[idx] = val;
  endtask

  // Strobe, optionally re-strobe mid-accumulation, then check the result.
  task automatic predict(input logic [N-1:0] c, input bit extra, input string req);
    int e;
    int act;
    e = exp_sum(c);
    @(negedge clk);
    chal = c; pred_go = 1'b1;
    @(negedge clk);
    pred_go = 1'b0;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (extra && k == 2) begin pred_go = 1'b1; chal = ~c; end
      else pred_go = 1'b0;
    end
    check(pred_vld == 1'b0, "R8 early vld", int'(pred_vld), 0);
    @(negedge clk);
    act = int'(pred_diff);
    check(pred_vld == 1'b1, "R8 vld due", int'(pred_vld), 1);
    check(act == e, req, act, e);
    check(pred_bit == (e > 0), (e > 0) ? "R4 bit" : "R5 bit", int'(pred_bit), int'(e > 0));
    check(pred_tie == (e == 0), "R6 tie", int'(pred_tie), int'(e == 0));
    @(negedge clk);
    check(pred_vld == 1'b0 && int'(pred_diff) == e, "R8 pulse/hold", int'(pred_vld), 0);
    if (extra) begin
      int seen = 0;
      for (int k = 0; k < N + 1; k++) begin
        @(negedge clk);
        if (pred_vld) seen++;
      end
      check(seen == 0 && int'(pred_diff) == e, "R9 ignored strobe", seen, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(pred_vld == 0 && pred_diff == 0 && pred_bit == 0 && pred_tie == 0,
          "R1 in reset", int'(pred_diff), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pred_vld == 0 && pred_diff == 0 && pred_bit == 0 && pred_tie == 0,
          "R1 after reset", int'(pred_diff), 0);

    wr(0, 120); wr(1, -45); wr(2, 30); wr(3, -200);
    wr(4, 75);  wr(5, 10);  wr(6, 45); wr(7, -5);

    predict(8'h00, 1'b0, "R7 reference");
    check(pred_tie == 1'b1, "R7 tie", int'(pred_tie), 1);
    predict(8'h07, 1'b0, "R3 low three");
    predict(8'h0A, 1'b0, "R5 negative sum");
    predict(8'h42, 1'b0, "R6 cancel");
    predict(8'h07, 1'b1, "R9 value");
    wr(2, -500);
    predict(8'h07, 1'b0, "R2 rewrite");
    predict(8'h80, 1'b0, "R2 top bit");

    for (int i = 0; i < N; i++) wr(i, -32768);
    predict(8'hFF, 1'b0, "R10 min");
    for (int i = 0; i < N; i++) wr(i, 32767);
    predict(8'hFF, 1'b0, "R10 max");

    for (int i = 0; i < N; i++) wr(i, int'($urandom_range(4000)) - 2000);
    for (int t = 0; t < 40; t++) begin
      predict(N'($urandom), (t % 10) == 3, "R3 random");
      if (t % 8 == 7) wr(int'($urandom_range(N - 1)), int'($urandom_range(65535)) - 32768);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule